// File: doc/BRIEF.md
# Banked Per-Pin GPIO Configuration Registers

This block holds the configuration of a group of general-purpose pins and drives them. Every pin has exactly one byte-wide location on a small synchronous register bus. The location is indirect: a written byte either stores a 4-bit value into one of six per-pin sub-banks or picks the sub-bank that the next read of that location returns. The top bit of the written byte decides which of the two happens.

The stored fields set each pin's direction mode, output level, open-drain behaviour, drive strength, tristate flag, polarity inversion and function select. Each pin comes out as a registered output-enable and output-data pair, a registered 3-bit function code and a synchronised, polarity-corrected input level. Bank 0 (supply select) and bank 2 (bias code) are only stored and read back here, because the analog side that uses them lies outside this block.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin i, for i from 0 to NUM_PINS-1, is reached at bus address BASE_ADDR+i (default 0x150), and each pin's storage is independent of every other pin's.
- R2: A write whose bit 7 is 1 and whose bits 6:4 hold a bank number from 0 to 5 stores bits 3:0 into that bank of the addressed pin. It does not change that pin's read selector.
- R3: A write whose bit 7 is 0 and whose bits 6:4 hold 0 to 5 only sets the pin's read selector. A read returns {4'b0000, selected bank nibble} on bus_rdata in the cycle after bus_rd_en is sampled. bus_rdata then holds until the next read. Reads and writes never share a cycle.
- R4: Field positions are as follows. Bank 1 has mode in bits 3:2 (0 input, 1 both, 2 output, 3 off), open-drain in bit 1 and level in bit 0. Bank 3 has strength in bits 3:2 (0 = none) and tristate in bit 0. Bank 4 has the function code in bits 3:1, which appears on pin_func[3i+2:3i]. Bank 5 bit 3 = 0 means the pin is inverted.
- R5: pin_oe is 1 only when the mode is 1 or 2, the tristate flag is 0, the strength is non-zero, and the open-drain rule below allows it.
- R6: pin_out is the stored level XOR the inversion. With open-drain selected, pin_oe is 0 whenever that value is 1.
- R7: pin_oe, pin_out and pin_func follow a storing write one clock after the write is sampled.
- R8: pin_rx is pin_in after two flip-flops, XOR the inversion. A change of pin_in shows on the second rising edge after it.
- R9: After reset every bank is 0, except bank 5, which is 4'b1000 (not inverted). Every read selector points at bank 0, and pin_oe, pin_out and pin_func are 0.
- R10: A write to an address outside BASE_ADDR..BASE_ADDR+NUM_PINS-1 changes nothing, and a read from such an address returns 0.
- R11: A write whose bits 6:4 are 6 or 7 changes nothing, whether it is a store or a select. The previous read selector stays in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output data |
| pin_rx | output | NUM_PINS | Synchronised input level after polarity correction |
| pin_func | output | 3*NUM_PINS | Per-pin function code |

## Verification
The assertions assume that bus_wr_en and bus_rd_en never rise in the same cycle, and one property checks that assumption at the port. The bench issues every access through separate write and read tasks, each of which raises one strobe for a single cycle, so a collision cannot occur. The open-drain and output-enable properties treat pin_oe and pin_out as a one-cycle-late view of bank state. The bench therefore samples them one full cycle after the last configuring write. It changes pin_in only on falling edges, so the synchroniser sees clean steps.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NIB_W      = 4;
  localparam int BANK_COUNT = 6;
  localparam int SEL_W      = 3;
  localparam int FUNC_W     = 3;
  localparam int CELL_W     = NIB_W * BANK_COUNT;

  // bank indices; positions matter because software decodes them
  localparam int BK_SUPPLY = 0;
  localparam int BK_DIR    = 1;
  localparam int BK_BIAS   = 2;
  localparam int BK_DRIVE  = 3;
  localparam int BK_FUNC   = 4;
  localparam int BK_POL    = 5;

  localparam logic [NIB_W-1:0] POL_RESET = 4'b1000;

  typedef enum logic [1:0] {
    MODE_IN    = 2'd0,
    MODE_BIDIR = 2'd1,
    MODE_OUT   = 2'd2,
    MODE_OFF   = 2'd3
  } pin_mode_e;

  typedef struct packed {
    pin_mode_e         mode;
    logic              od;
    logic              level;
    logic [1:0]        strength;
    logic              hiz;
    logic [FUNC_W-1:0] func;
    logic              inv;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(input logic [CELL_W-1:0] banks);
    pin_cfg_t c;
    logic [NIB_W-1:0] dir_n, drv_n, fn_n, pol_n;
    dir_n      = banks[BK_DIR*NIB_W   +: NIB_W];
    drv_n      = banks[BK_DRIVE*NIB_W +: NIB_W];
    fn_n       = banks[BK_FUNC*NIB_W  +: NIB_W];
    pol_n      = banks[BK_POL*NIB_W   +: NIB_W];
    c.mode     = pin_mode_e'(dir_n[3:2]);
    c.od       = dir_n[1];
    c.level    = dir_n[0];
    c.strength = drv_n[3:2];
    c.hiz      = drv_n[0];
    c.func     = fn_n[3:1];
    c.inv      = ~pol_n[3];
    return c;
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int NUM_PINS  = 44,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 336,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  output logic                hit,
  output logic [PIN_W-1:0]    pin_idx,
  output logic [NUM_PINS-1:0] wr_sel
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset  = addr - ADDR_W'(BASE_ADDR);
    hit     = (addr >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NUM_PINS));
    pin_idx = offset[PIN_W-1:0];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && hit && (pin_idx == PIN_W'(i));
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic              pin_level,
  output logic [CELL_W-1:0] banks_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              oe_o,
  output logic              out_o,
  output logic [FUNC_W-1:0] func_o,
  output logic              rx_o
);
  logic [CELL_W-1:0] bank_q;
  logic [SEL_W-1:0]  sel_q;
  logic [1:0]        sync_q;
  logic              oe_q, out_q;
  logic [FUNC_W-1:0] func_q;
  logic              bank_ok, is_store;
  pin_cfg_t          cfg;
  logic              level_eff, drive_ok, oe_next;

  assign bank_ok  = wr_data[6:4] < SEL_W'(BANK_COUNT);
  assign is_store = wr_data[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      bank_q[BK_POL*NIB_W +: NIB_W] <= POL_RESET;
    end else if (wr_stb && is_store && bank_ok) begin
      for (int b = 0; b < BANK_COUNT; b++) begin
        if (wr_data[6:4] == SEL_W'(b)) bank_q[b*NIB_W +: NIB_W] <= wr_data[3:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                sel_q <= '0;
    else if (wr_stb && !is_store && bank_ok) sel_q <= wr_data[6:4];
  end

  always_comb begin
    cfg       = unpack_cfg(bank_q);
    level_eff = cfg.level ^ cfg.inv;
    drive_ok  = ((cfg.mode == MODE_OUT) || (cfg.mode == MODE_BIDIR)) &&
                !cfg.hiz && (cfg.strength != 2'd0);
    oe_next   = drive_ok && (!cfg.od || !level_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      out_q  <= 1'b0;
      func_q <= '0;
      sync_q <= '0;
    end else begin
      oe_q   <= oe_next;
      out_q  <= level_eff;
      func_q <= cfg.func;
      sync_q <= {sync_q[0], pin_level};
    end
  end

  assign banks_o = bank_q;
  assign sel_o   = sel_q;
  assign oe_o    = oe_q;
  assign out_o   = out_q;
  assign func_o  = func_q;
  assign rx_o    = sync_q[1] ^ cfg.inv;
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 44,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic                       hit,
  input  logic [PIN_W-1:0]           pin_idx,
  input  logic [NUM_PINS*CELL_W-1:0] banks_all,
  input  logic [NUM_PINS*SEL_W-1:0]  sel_all,
  output logic [7:0]                 rdata
);
  logic [SEL_W-1:0] sel_now;
  logic [NIB_W-1:0] nib_now;

  always_comb begin
    sel_now = sel_all[pin_idx*SEL_W +: SEL_W];
    nib_now = banks_all[pin_idx*CELL_W + sel_now*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= hit ? {4'b0000, nib_now} : 8'h00;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 44,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 336
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_rx,
  output logic [NUM_PINS*FUNC_W-1:0] pin_func
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic                       addr_hit;
  logic [PIN_W-1:0]           addr_pin;
  logic [NUM_PINS-1:0]        wr_sel;
  logic [NUM_PINS*CELL_W-1:0] bank_state;
  logic [NUM_PINS*SEL_W-1:0]  sel_state;

  gpio_addr_dec #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) dec_i (
    .addr(bus_addr), .wr_en(bus_wr_en),
    .hit(addr_hit), .pin_idx(addr_pin), .wr_sel(wr_sel)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_cell cell_i (
      .clk(clk), .rst(rst),
      .wr_stb(wr_sel[i]), .wr_data(bus_wdata),
      .pin_level(pin_in[i]),
      .banks_o(bank_state[i*CELL_W +: CELL_W]),
      .sel_o(sel_state[i*SEL_W +: SEL_W]),
      .oe_o(pin_oe[i]), .out_o(pin_out[i]),
      .func_o(pin_func[i*FUNC_W +: FUNC_W]),
      .rx_o(pin_rx[i])
    );
  end

  gpio_rd_port #(.NUM_PINS(NUM_PINS)) rd_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .hit(addr_hit),
    .pin_idx(addr_pin), .banks_all(bank_state), .sel_all(sel_state),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 44,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 336
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr_en,
  input logic                       bus_rd_en,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [7:0]                 bus_wdata,
  input logic [7:0]                 bus_rdata,
  input logic [NUM_PINS-1:0]        pin_oe,
  input logic [NUM_PINS-1:0]        pin_out,
  input logic [NUM_PINS*CELL_W-1:0] bank_state
);
  logic in_range;
  logic rst_d;

  always_comb
    in_range = (int'(bus_addr) >= BASE_ADDR) && (int'(bus_addr) < BASE_ADDR + NUM_PINS);

  always_ff @(posedge clk) rst_d <= rst;

  assert_no_rw_collision_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && bus_rd_en));

  assert_oob_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !in_range) |=> (bus_rdata == 8'h00));

  assert_oob_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && !in_range) |=> $stable(bank_state));

  assert_bad_bank_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && (bus_wdata[6:4] > 3'd5)) |=> $stable(bank_state));

  // R9: first cycle out of reset has every driver off
  always @(posedge clk) begin
    if (rst_d && !rst) assert_reset_quiet_R9: assert (pin_oe == '0);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
    localparam int DIR_OFS = i*CELL_W + BK_DIR*NIB_W;
    localparam int DRV_OFS = i*CELL_W + BK_DRIVE*NIB_W;

    assert_od_no_high_R6: assert property (@(posedge clk) disable iff (rst)
      (pin_oe[i] && pin_out[i]) |-> !$past(bank_state[DIR_OFS + 1]));

    assert_oe_needs_mode_R5: assert property (@(posedge clk) disable iff (rst)
      pin_oe[i] |-> ($past(bank_state[DIR_OFS + 2 +: 2]) == 2'd1 ||
                     $past(bank_state[DIR_OFS + 2 +: 2]) == 2'd2));

    assert_oe_needs_drive_R5: assert property (@(posedge clk) disable iff (rst)
      pin_oe[i] |-> ($past(bank_state[DRV_OFS + 2 +: 2]) != 2'd0 &&
                     !$past(bank_state[DRV_OFS])));
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_out(pin_out), .bank_state(bank_state)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  localparam int NP   = 4;
  localparam int AW   = 12;
  localparam int BASE = 336;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_out, pin_rx;
  logic [NP*3-1:0] pin_func;

  int n_checks = 0;
  int n_errors = 0;
  logic [3:0] model [NP][6];

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_rx(pin_rx),
    .pin_func(pin_func)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input int data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = 8'(data); bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input int addr, output int data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    data = int'(bus_rdata);
  endtask

  task automatic read_bank(input int p, input int b, output int data);
    bus_write(BASE + p, b << 4);
    bus_read(BASE + p, data);
  endtask

  task automatic check_all_banks(input string req);
    int v;
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < 6; b++) begin
        read_bank(p, b, v);
        check(req, v, int'(model[p][b]));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int v;
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < 6; b++) model[p][b] = (b == 5) ? 4'h8 : 4'h0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 oe", int'(pin_oe), 0);
    check("R9 out", int'(pin_out), 0);
    check("R9 func", int'(pin_func), 0);
    check("R9 rx", int'(pin_rx), 0);
    bus_read(BASE + 2, v);
    check("R9 selector at bank 0", v, 0);
    check_all_banks("R9 bank reset");

    // R1 R2 store sweep, two patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < NP; p++)
        for (int b = 0; b < 6; b++) begin
          int nib = (p*5 + b*3 + 1 + pass*7) & 15;
          bus_write(BASE + p, 8'h80 | (b << 4) | nib);
          model[p][b] = 4'(nib);
        end
      check_all_banks("R1 R2 store and read back");
    end

    // R3 selector persists across a store
    bus_write(BASE + 0, 8'h20);
    bus_write(BASE + 0, 8'hC5);
    model[0][4] = 4'h5;
    bus_read(BASE + 0, v);
    check("R3 store keeps selector", v, int'(model[0][2]));
    bus_read(BASE + 0, v);
    check("R3 repeated read", v, int'(model[0][2]));

    // R11 banks 6 and 7 ignored
    bus_write(BASE + 3, 8'h10);
    bus_write(BASE + 3, 8'hE7);
    bus_write(BASE + 3, 8'hF9);
    bus_write(BASE + 3, 8'h60);
    bus_write(BASE + 3, 8'h70);
    bus_read(BASE + 3, v);
    check("R11 selector unchanged", v, int'(model[3][1]));
    check_all_banks("R11 banks unchanged");

    // R10 out-of-range
    bus_write(BASE + NP, 8'h8F);
    bus_write(BASE - 1, 8'h9F);
    bus_write(4095, 8'hBC);
    bus_read(BASE + NP, v);
    check("R10 read above range", v, 0);
    bus_read(BASE - 1, v);
    check("R10 read below range", v, 0);
    bus_read(0, v);
    check("R10 read address 0", v, 0);
    check_all_banks("R10 writes ignored");

    // R4 function field
    for (int f = 0; f < 8; f++) begin
      bus_write(BASE + 3, 8'hC0 | (f << 1));
      @(negedge clk);
      check("R4 function output", int'(pin_func[9 +: 3]), f);
    end

    // R7 latency on pin 0
    bus_write(BASE + 0, 8'hD8);
    bus_write(BASE + 0, 8'hB4);
    bus_write(BASE + 0, 8'h90);
    @(negedge clk);
    check("R7 oe before", int'(pin_oe[0]), 0);
    bus_write(BASE + 0, 8'h99);
    check("R7 oe not yet", int'(pin_oe[0]), 0);
    check("R7 out not yet", int'(pin_out[0]), 0);
    @(negedge clk);
    check("R7 oe after one clock", int'(pin_oe[0]), 1);
    check("R7 out after one clock", int'(pin_out[0]), 1);

    // R5 R6 drive sweep on pin 1
    for (int m = 0; m < 4; m++)
      for (int od = 0; od < 2; od++)
        for (int lv = 0; lv < 2; lv++)
          for (int st = 0; st < 4; st++)
            for (int hz = 0; hz < 2; hz++)
              for (int iv = 0; iv < 2; iv++) begin
                int eff, eoe;
                bus_write(BASE + 1, iv ? 8'hD0 : 8'hD8);
                bus_write(BASE + 1, 8'hB0 | (st << 2) | hz);
                bus_write(BASE + 1, 8'h90 | (m << 2) | (od << 1) | lv);
                @(negedge clk);
                eff = lv ^ iv;
                eoe = ((m == 1 || m == 2) && hz == 0 && st != 0 &&
                       (od == 0 || eff == 0)) ? 1 : 0;
                check("R5 R6 output enable", int'(pin_oe[1]), eoe);
                check("R6 output data", int'(pin_out[1]), eff);
                check("R1 pin 2 untouched", int'(pin_oe[2]), 0);
              end

    // R8 synchroniser, pin 2 inverted, pin 3 not
    bus_write(BASE + 2, 8'hD0);
    bus_write(BASE + 3, 8'hD8);
    repeat (3) @(negedge clk);
    check("R8 inverted idle", int'(pin_rx[2]), 1);
    check("R8 plain idle", int'(pin_rx[3]), 0);
    pin_in[2] = 1'b1; pin_in[3] = 1'b1;
    @(negedge clk);
    check("R8 inverted after one edge", int'(pin_rx[2]), 1);
    check("R8 plain after one edge", int'(pin_rx[3]), 0);
    @(negedge clk);
    check("R8 inverted after two edges", int'(pin_rx[2]), 0);
    check("R8 plain after two edges", int'(pin_rx[3]), 1);
    pin_in[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 plain falls", int'(pin_rx[3]), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule